// File: doc/BRIEF.md
# Bridge Configuration Register File with Indirect Access Port

This block holds the 256-byte configuration space of a host-to-PCI bridge. A host can reach it in two ways. The first is a direct port that takes byte, halfword and word reads and writes, with big-endian lane ordering. The second is an address/data register pair. A word written to the address register either opens a four-byte window onto the internal space or is sent to a downstream configuration bus. Later accesses to the data register read or update that window through a four-byte shadow.

Reset clears the space and then loads a default image. A device-select input picks one of two variants of that image. Multi-byte defaults are laid out with the least significant byte at the lowest offset. A big-endian read of such a field therefore returns its bytes reversed.

The direct port has fixed priority over the indirect port. Each port holds its request until it sees a one-cycle acknowledge. The port does not start a new operation while its own acknowledge is high.

Top module: `cfg_bridge_regs`

## Requirements
- R1: Reset clears every byte to zero and then loads defaults, least significant byte first. The defaults are: 0x1057 at 0x00; device ID 1, or 2 when `dev_sel`=1, at 0x02; 0x0006 at 0x04; 0x0080 at 0x06; 0x06 at 0x0B; 0x04 at 0xBA; 0x01 at 0xC0; 0xFF000010 at 0xA8; 0x000C060C at 0xAC; 0xFF020000 at 0xF0; 0x00000003 at 0xF4; 0x00100000 at 0xFC. When `dev_sel`=1, reset also loads 0x08 at 0x0C, 0xCD at 0x73, 0x0FFF0042 at 0xE0 and 0x00000020 at 0xE8.
- R2: A direct read uses size codes 0=byte, 1=half, 2 or 3=word. Word reads clear address bits 1:0 and half reads clear bit 0. The byte at the lowest address is the most significant byte of the result, the result is zero-extended, and `dir_ack` and `dir_rdata` appear one cycle after acceptance.
- R3: A direct write stores its data big-endian into the same bytes a read of that size and address would return. Byte data is taken from bits 7:0, half data from bits 15:0 and word data from bits 31:0.
- R4: An indirect word write to the address register (`ind_sel`=0) whose bits 23:0 equal 0x000080 sets the pointer to bits 31:24. It also copies the bytes at pointer+0..3 into the shadow, with the byte at pointer+0 in bits 31:24.
- R5: Any other address-register word write, while `ds_present`=1, raises `ds_req` the next cycle with `ds_addr` equal to the byte-swapped write data. `ds_req` and `ds_addr` hold until a cycle with `ds_valid`=1. In that cycle the shadow takes the byte-swapped `ds_rdata`, and `ind_ack` follows one cycle later.
- R6: When `ds_present`=0, such a write loads the shadow with 0xFFFFFFFF, never raises `ds_req`, and is acknowledged the next cycle.
- R7: Data-register reads (`ind_sel`=1) return shadow bytes. A byte read selects lane `ind_addr`[1:0], a half read selects the half by `ind_addr`[1], and a word read ignores `ind_addr`. Lane 0 is bits 31:24 of the shadow.
- R8: A data-register write updates both the shadow lanes and the array bytes at pointer plus lane number. It uses the same lane selection and data alignment as R3.
- R9: Pointer plus lane number wraps modulo 256.
- R10: When both ports start an operation in the same cycle, the direct port is served first and the indirect operation completes in a later cycle.
- R11: Byte and half writes to the address register change neither the pointer nor the shadow. Reads of the address register return zero.
- R12: Reset clears the pointer and the shadow, and drops `ds_req` and both acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | Selects the default image variant |
| dir_req | input | 1 | Direct port request, held until acknowledged |
| dir_we | input | 1 | Direct port write |
| dir_size | input | 2 | Direct access size: 0 byte, 1 half, 2/3 word |
| dir_addr | input | 8 | Direct byte address |
| dir_wdata | input | 32 | Direct write data |
| dir_ack | output | 1 | Direct completion pulse |
| dir_rdata | output | 32 | Direct read data |
| ind_req | input | 1 | Indirect port request, held until acknowledged |
| ind_we | input | 1 | Indirect port write |
| ind_sel | input | 1 | 0 address register, 1 data register |
| ind_size | input | 2 | Indirect access size, same coding |
| ind_addr | input | 2 | Lane offset within the data register |
| ind_wdata | input | 32 | Indirect write data |
| ind_ack | output | 1 | Indirect completion pulse |
| ind_rdata | output | 32 | Indirect read data |
| ds_present | input | 1 | A downstream configuration responder is attached |
| ds_req | output | 1 | Downstream request, held until response |
| ds_addr | output | 32 | Byte-swapped forwarded command |
| ds_valid | input | 1 | Downstream response valid |
| ds_rdata | input | 32 | Downstream response data |

## Verification
A wrong pointer or a stale shadow has no effect on the direct port. It shows up on the next data-register read, or on the next direct read of bytes that a data-register write should have reached. The bench therefore reads back through the other port after every indirect write. A mis-set default byte appears on the first direct read of its word, so all 64 words are read after each reset. A handshake fault appears at once, either as a moving `ds_addr` or as an acknowledge that comes early or never arrives.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [23:0] INT_PATTERN = 24'h000080;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // default image, least significant byte at lowest offset
  function automatic logic [7:0] reset_byte(input int idx, input logic ext);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      8'h00: b = 8'h57;  8'h01: b = 8'h10;
      8'h02: b = ext ? 8'h02 : 8'h01;
      8'h04: b = 8'h06;  8'h06: b = 8'h80;
      8'h0B: b = 8'h06;
      8'hA8: b = 8'h10;  8'hAB: b = 8'hFF;
      8'hAC: b = 8'h0C;  8'hAD: b = 8'h06;  8'hAE: b = 8'h0C;
      8'hBA: b = 8'h04;  8'hC0: b = 8'h01;
      8'hF2: b = 8'h02;  8'hF3: b = 8'hFF;
      8'hF4: b = 8'h03;  8'hFE: b = 8'h10;
      default: b = 8'h00;
    endcase
    if (ext) begin
      case (idx)
        8'h0C: b = 8'h08;
        8'h73: b = 8'hCD;
        8'hE0: b = 8'h42;  8'hE2: b = 8'hFF;  8'hE3: b = 8'h0F;
        8'hE8: b = 8'h20;
        default: ;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/cfgb_lanes.sv
module cfgb_lanes
  import cfgb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [1:0]    size,
  input  logic [1:0]    lo,
  input  logic [AW-1:0] base,
  input  logic [31:0]   wdata,
  input  logic [31:0]   rword,
  output logic [AW-1:0] addr [4],
  output logic [3:0]    en,
  output logic [7:0]    wbyte [4],
  output logic [31:0]   rdata
);
  logic [1:0]  last;
  logic [31:0] shifted;

  always_comb begin
    en   = 4'b0000;
    last = 2'd3;
    case (size)
      SZ_BYTE: begin en[lo] = 1'b1; last = lo; end
      SZ_HALF: begin
        en[{lo[1], 1'b0}] = 1'b1;
        en[{lo[1], 1'b1}] = 1'b1;
        last = {lo[1], 1'b1};
      end
      default: begin en = 4'b1111; last = 2'd3; end
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign addr[k] = base + AW'(k);
    always_comb begin
      if (int'(last) >= k) wbyte[k] = wdata[8*(int'(last)-k) +: 8];
      else                 wbyte[k] = 8'h00;
    end
  end

  always_comb begin
    shifted = rword >> (8 * (3 - int'(last)));
    case (size)
      SZ_BYTE: rdata = {24'h0, shifted[7:0]};
      SZ_HALF: rdata = {16'h0, shifted[15:0]};
      default: rdata = shifted;
    endcase
  end
endmodule

// File: rtl/cfgb_regfile.sv
module cfgb_regfile
  import cfgb_pkg::*;
#(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_sel,
  input  logic [3:0]    we,
  input  logic [AW-1:0] waddr [4],
  input  logic [7:0]    wbyte [4],
  input  logic [AW-1:0] raddr [4],
  output logic [31:0]   rword
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= reset_byte(i, dev_sel);
    end else begin
      for (int k = 0; k < 4; k++)
        if (we[k]) mem[waddr[k]] <= wbyte[k];
    end
  end

  assign rword = {mem[raddr[0]], mem[raddr[1]], mem[raddr[2]], mem[raddr[3]]};
endmodule

// File: rtl/cfgb_indirect.sv
module cfgb_indirect
  import cfgb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          sel,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  input  logic [31:0]   arr_word,
  input  logic [3:0]    lane_en,
  input  logic [7:0]    lane_wbyte [4],
  input  logic [31:0]   lane_rdata,
  input  logic          ds_present,
  input  logic          ds_valid,
  input  logic [31:0]   ds_rdata,
  output logic [AW-1:0] ptr,
  output logic [31:0]   shadow,
  output logic          ack,
  output logic [31:0]   rdata,
  output logic          ds_req,
  output logic [31:0]   ds_addr
);
  logic is_word;
  assign is_word = (size != SZ_BYTE) && (size != SZ_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      shadow  <= '0;
      ack     <= 1'b0;
      rdata   <= '0;
      ds_req  <= 1'b0;
      ds_addr <= '0;
    end else begin
      ack <= 1'b0;
      if (ds_req) begin
        if (ds_valid) begin
          shadow <= bswap32(ds_rdata);
          ds_req <= 1'b0;
          ack    <= 1'b1;
        end
      end else if (go) begin
        if (!sel) begin
          if (!we) begin
            rdata <= '0;
            ack   <= 1'b1;
          end else if (!is_word) begin
            ack <= 1'b1;
          end else if (wdata[23:0] == INT_PATTERN) begin
            ptr    <= AW'(wdata[31:24]);
            shadow <= arr_word;
            ack    <= 1'b1;
          end else if (!ds_present) begin
            shadow <= 32'hFFFF_FFFF;
            ack    <= 1'b1;
          end else begin
            ds_req  <= 1'b1;
            ds_addr <= bswap32(wdata);
          end
        end else if (we) begin
          for (int k = 0; k < 4; k++)
            if (lane_en[k]) shadow[31-8*k -: 8] <= lane_wbyte[k];
          ack <= 1'b1;
        end else begin
          rdata <= lane_rdata;
          ack   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs
  import cfgb_pkg::*;
#(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_sel,
  input  logic          dir_req,
  input  logic          dir_we,
  input  logic [1:0]    dir_size,
  input  logic [AW-1:0] dir_addr,
  input  logic [31:0]   dir_wdata,
  output logic          dir_ack,
  output logic [31:0]   dir_rdata,
  input  logic          ind_req,
  input  logic          ind_we,
  input  logic          ind_sel,
  input  logic [1:0]    ind_size,
  input  logic [1:0]    ind_addr,
  input  logic [31:0]   ind_wdata,
  output logic          ind_ack,
  output logic [31:0]   ind_rdata,
  input  logic          ds_present,
  output logic          ds_req,
  output logic [31:0]   ds_addr,
  input  logic          ds_valid,
  input  logic [31:0]   ds_rdata
);
  logic          dir_go, ind_go;
  logic [AW-1:0] ptr;
  logic [31:0]   shadow, arr_word;
  logic [AW-1:0] d_addr [4];
  logic [AW-1:0] i_addr [4];
  logic [7:0]    d_wb [4];
  logic [7:0]    i_wb [4];
  logic [3:0]    d_en, i_en, rf_we;
  logic [31:0]   d_rd, i_rd;
  logic [AW-1:0] i_base;
  logic [1:0]    i_size;
  logic [AW-1:0] rf_waddr [4];
  logic [AW-1:0] rf_raddr [4];
  logic [7:0]    rf_wb [4];

  assign dir_go = dir_req && !dir_ack;
  assign ind_go = ind_req && !ind_ack && !ds_req && !dir_go;

  assign i_base = ind_sel ? ptr : AW'(ind_wdata[31:24]);
  assign i_size = ind_sel ? ind_size : SZ_WORD;

  cfgb_lanes #(.AW(AW)) u_dlanes (
    .size(dir_size), .lo(dir_addr[1:0]), .base({dir_addr[AW-1:2], 2'b00}),
    .wdata(dir_wdata), .rword(arr_word),
    .addr(d_addr), .en(d_en), .wbyte(d_wb), .rdata(d_rd));

  cfgb_lanes #(.AW(AW)) u_ilanes (
    .size(i_size), .lo(ind_addr), .base(i_base),
    .wdata(ind_wdata), .rword(shadow),
    .addr(i_addr), .en(i_en), .wbyte(i_wb), .rdata(i_rd));

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rf_raddr[k] = dir_go ? d_addr[k] : i_addr[k];
      rf_waddr[k] = dir_go ? d_addr[k] : i_addr[k];
      rf_wb[k]    = dir_go ? d_wb[k]   : i_wb[k];
    end
    if (dir_go && dir_we)                 rf_we = d_en;
    else if (ind_go && ind_sel && ind_we) rf_we = i_en;
    else                                  rf_we = 4'b0000;
  end

  cfgb_regfile #(.BYTES(BYTES)) u_rf (
    .clk(clk), .rst(rst), .dev_sel(dev_sel),
    .we(rf_we), .waddr(rf_waddr), .wbyte(rf_wb),
    .raddr(rf_raddr), .rword(arr_word));

  cfgb_indirect #(.AW(AW)) u_ind (
    .clk(clk), .rst(rst), .go(ind_go), .sel(ind_sel), .we(ind_we),
    .size(ind_size), .wdata(ind_wdata), .arr_word(arr_word),
    .lane_en(i_en), .lane_wbyte(i_wb), .lane_rdata(i_rd),
    .ds_present(ds_present), .ds_valid(ds_valid), .ds_rdata(ds_rdata),
    .ptr(ptr), .shadow(shadow), .ack(ind_ack), .rdata(ind_rdata),
    .ds_req(ds_req), .ds_addr(ds_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_ack   <= 1'b0;
      dir_rdata <= '0;
    end else begin
      dir_ack <= dir_go;
      if (dir_go && !dir_we) dir_rdata <= d_rd;
    end
  end
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
  input logic        clk,
  input logic        rst,
  input logic        dir_req,
  input logic        dir_ack,
  input logic        ind_req,
  input logic        ind_ack,
  input logic        ds_present,
  input logic        ds_req,
  input logic [31:0] ds_addr,
  input logic        ds_valid
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!dir_ack && !ind_ack && !ds_req)); // R12
  AST_DIR_PULSE: assert property (@(posedge clk) disable iff (rst)
    dir_ack |=> !dir_ack); // R2
  AST_DS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ds_req && !ds_valid) |=> (ds_req && $stable(ds_addr))); // R5
  AST_DS_ACK_AFTER: assert property (@(posedge clk) disable iff (rst)
    (ds_req && ds_valid) |=> (ind_ack && !ds_req)); // R5
  AST_NO_ACK_WHILE_FWD: assert property (@(posedge clk) disable iff (rst)
    ds_req |-> !ind_ack); // R5
  AST_ABSENT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_req) |-> $past(ds_present)); // R6
  AST_DIR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (dir_req && !dir_ack && ind_req && !ind_ack && !ds_req) |=> (dir_ack && !ind_ack)); // R10
endmodule

bind cfg_bridge_regs cfgb_checker u_chk (
  .clk(clk), .rst(rst), .dir_req(dir_req), .dir_ack(dir_ack),
  .ind_req(ind_req), .ind_ack(ind_ack), .ds_present(ds_present),
  .ds_req(ds_req), .ds_addr(ds_addr), .ds_valid(ds_valid));

// File: tb/cfg_bridge_regs_bench.sv
module cfg_bridge_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_sel = 1'b0;
  logic dir_req = 0, dir_we = 0;
  logic [1:0] dir_size = 0;
  logic [7:0] dir_addr = 0;
  logic [31:0] dir_wdata = 0;
  logic dir_ack;
  logic [31:0] dir_rdata;
  logic ind_req = 0, ind_we = 0, ind_sel = 0;
  logic [1:0] ind_size = 0, ind_addr = 0;
  logic [31:0] ind_wdata = 0;
  logic ind_ack;
  logic [31:0] ind_rdata;
  logic ds_present = 0, ds_valid = 0;
  logic [31:0] ds_rdata = 0;
  logic ds_req;
  logic [31:0] ds_addr;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m [256];
  logic [7:0] sh [4];
  logic [7:0] mptr;
  logic [31:0] seen_addr;
  bit forbid_ds = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_bridge_regs u_cfg_bridge_regs (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] resp_for(logic [31:0] a);
    return a ^ 32'hA5C3_0F11;
  endfunction

  task automatic put32(int off, logic [31:0] v);
    for (int i = 0; i < 4; i++) m[off+i] = v[8*i +: 8];
  endtask

  task automatic load_model(bit ext);
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    put32(8'h00, {16'h0000 | (ext ? 16'd2 : 16'd1), 16'h1057});
    put32(8'h04, 32'h0080_0006);
    m[8'h0B] = 8'h06; m[8'hBA] = 8'h04; m[8'hC0] = 8'h01;
    put32(8'hA8, 32'hFF00_0010); put32(8'hAC, 32'h000C_060C);
    put32(8'hF0, 32'hFF02_0000); put32(8'hF4, 32'h0000_0003);
    put32(8'hFC, 32'h0010_0000);
    if (ext) begin
      m[8'h0C] = 8'h08; m[8'h73] = 8'hCD;
      put32(8'hE0, 32'h0FFF_0042); put32(8'hE8, 32'h0000_0020);
    end
    for (int k = 0; k < 4; k++) sh[k] = 8'h00;
    mptr = 8'h00;
  endtask

  // expected read value given a 4-byte big-endian source and size/offset
  function automatic logic [31:0] pick(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                                       logic [7:0] b3, logic [1:0] sz, logic [1:0] lo);
    logic [7:0] b [4];
    b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
    if (sz == 2'd0) return {24'h0, b[lo]};
    if (sz == 2'd1) return {16'h0, b[{lo[1],1'b0}], b[{lo[1],1'b1}]};
    return {b0, b1, b2, b3};
  endfunction

  task automatic do_reset(bit ext);
    @(negedge clk);
    rst = 1; dev_sel = ext;
    repeat (2) @(negedge clk);
    check("R12 ack/req low in reset", {29'h0, dir_ack, ind_ack, ds_req}, 32'h0);
    rst = 0;
    load_model(ext);
  endtask

  task automatic wait_dir();
    do @(posedge clk); while (!dir_ack);
    #1;
  endtask

  task automatic wait_ind();
    do @(posedge clk); while (!ind_ack);
    #1;
  endtask

  task automatic dir_op(string req, bit we, logic [1:0] sz, logic [7:0] a, logic [31:0] wd);
    logic [7:0] base;
    logic [31:0] exp;
    base = {a[7:2], 2'b00};
    exp = pick(m[base], m[base+1], m[base+2], m[base+3], sz, a[1:0]);
    @(negedge clk);
    dir_req = 1; dir_we = we; dir_size = sz; dir_addr = a; dir_wdata = wd;
    wait_dir();
    dir_req = 0;
    if (!we) check(req, dir_rdata, exp);
    else begin
      if (sz == 2'd0) m[a] = wd[7:0];
      else if (sz == 2'd1) begin
        m[{a[7:1],1'b0}] = wd[15:8]; m[{a[7:1],1'b1}] = wd[7:0];
      end else for (int i = 0; i < 4; i++) m[base+i] = wd[31-8*i -: 8];
    end
  endtask

  task automatic ind_op(string req, bit sel, bit we, logic [1:0] sz, logic [1:0] lo,
                        logic [31:0] wd);
    logic [31:0] exp;
    exp = pick(sh[0], sh[1], sh[2], sh[3], sz, lo);
    @(negedge clk);
    ind_req = 1; ind_sel = sel; ind_we = we; ind_size = sz; ind_addr = lo; ind_wdata = wd;
    wait_ind();
    ind_req = 0;
    if (!sel && !we) check(req, ind_rdata, 32'h0);
    else if (sel && !we) check(req, ind_rdata, exp);
    else if (sel && we) begin
      if (sz == 2'd0) begin sh[lo] = wd[7:0]; m[8'(mptr+lo)] = wd[7:0]; end
      else if (sz == 2'd1) begin
        sh[{lo[1],1'b0}] = wd[15:8]; m[8'(mptr+{lo[1],1'b0})] = wd[15:8];
        sh[{lo[1],1'b1}] = wd[7:0];  m[8'(mptr+{lo[1],1'b1})] = wd[7:0];
      end else for (int i = 0; i < 4; i++) begin
        sh[i] = wd[31-8*i -: 8]; m[8'(mptr+i)] = wd[31-8*i -: 8];
      end
    end else if (sz >= 2'd2) begin
      if (wd[23:0] == 24'h000080) begin
        mptr = wd[31:24];
        for (int i = 0; i < 4; i++) sh[i] = m[8'(mptr+i)];
      end else if (!ds_present) begin
        for (int i = 0; i < 4; i++) sh[i] = 8'hFF;
      end else begin
        check("R5 forwarded address", seen_addr, swap(wd));
        exp = swap(resp_for(swap(wd)));
        for (int i = 0; i < 4; i++) sh[i] = exp[31-8*i -: 8];
      end
    end
  endtask

  task automatic all_words(string req);
    for (int w = 0; w < 64; w++) dir_op(req, 0, 2'd2, 8'(w*4), 32'h0);
  endtask

  // downstream responder
  initial begin
    forever begin
      @(posedge clk); #1;
      if (ds_req && !ds_valid) begin
        seen_addr = ds_addr;
        repeat (2) @(negedge clk);
        check("R5 ds_addr held", ds_addr, seen_addr);
        ds_rdata = resp_for(ds_addr);
        ds_valid = 1;
        @(posedge clk); #1;
        ds_valid = 0;
      end
    end
  end

  // per-cycle observations
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R10 single ack per cycle", {31'h0, dir_ack && ind_ack}, 32'h0);
      if (forbid_ds) check("R6 no downstream request", {31'h0, ds_req}, 32'h0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset(0);
    all_words("R1 base defaults");
    ind_op("R12 shadow cleared", 1, 0, 2'd2, 2'd0, 0);
    dir_op("R2 byte read", 0, 2'd0, 8'h0B, 0);
    dir_op("R2 half read aligns", 0, 2'd1, 8'h07, 0);
    dir_op("R2 word read aligns", 0, 2'd2, 8'hA9, 0);
    dir_op("R2 size 3 is word", 0, 2'd3, 8'hF2, 0);
    // direct writes
    dir_op("R3 word write", 1, 2'd2, 8'h41, 32'h1122_3344);
    dir_op("R3 byte write", 1, 2'd0, 8'h45, 32'h0000_00AB);
    dir_op("R3 half write", 1, 2'd1, 8'h47, 32'h0000_C0DE);
    dir_op("R3 readback 40", 0, 2'd2, 8'h40, 0);
    dir_op("R3 readback 44", 0, 2'd2, 8'h44, 0);
    // internal window
    ind_op("R4 select", 0, 1, 2'd2, 2'd0, 32'h4000_0080);
    ind_op("R4 copied word", 1, 0, 2'd2, 2'd1, 0);
    for (int l = 0; l < 4; l++) ind_op("R7 byte lane", 1, 0, 2'd0, 2'(l), 0);
    ind_op("R7 half low", 1, 0, 2'd1, 2'd0, 0);
    ind_op("R7 half high", 1, 0, 2'd1, 2'd3, 0);
    ind_op("R8 byte write", 1, 1, 2'd0, 2'd2, 32'h0000_0099);
    ind_op("R8 half write", 1, 1, 2'd1, 2'd0, 32'h0000_BEEF);
    ind_op("R8 shadow after writes", 1, 0, 2'd2, 2'd0, 0);
    dir_op("R8 array after writes", 0, 2'd2, 8'h40, 0);
    // wrap
    ind_op("R9 select FE", 0, 1, 2'd2, 2'd0, 32'hFE00_0080);
    ind_op("R9 wrapped copy", 1, 0, 2'd2, 2'd0, 0);
    ind_op("R9 word write", 1, 1, 2'd2, 2'd0, 32'hCAFE_F00D);
    dir_op("R9 array FC", 0, 2'd2, 8'hFC, 0);
    dir_op("R9 array 00", 0, 2'd2, 8'h00, 0);
    // forwarding
    ds_present = 1;
    ind_op("R5 forward", 0, 1, 2'd2, 2'd0, 32'h1234_5678);
    ind_op("R5 shadow from response", 1, 0, 2'd2, 2'd0, 0);
    ind_op("R5 forward 2", 0, 1, 2'd2, 2'd0, 32'h8000_0180);
    ind_op("R5 shadow 2", 1, 0, 2'd2, 2'd0, 0);
    // absent responder
    ds_present = 0; forbid_ds = 1;
    ind_op("R6 absent", 0, 1, 2'd2, 2'd0, 32'h0000_0081);
    ind_op("R6 all ones", 1, 0, 2'd2, 2'd0, 0);
    forbid_ds = 0;
    // ignored sub-word address writes and address reads
    ind_op("R4 select 40", 0, 1, 2'd2, 2'd0, 32'h4000_0080);
    ind_op("R11 half addr write", 0, 1, 2'd1, 2'd0, 32'h0000_0080);
    ind_op("R11 byte addr write", 0, 1, 2'd0, 2'd0, 32'h0000_0010);
    ind_op("R11 shadow unchanged", 1, 0, 2'd2, 2'd0, 0);
    ind_op("R11 address read zero", 0, 0, 2'd2, 2'd0, 0);
    ind_op("R11 pointer unchanged write", 1, 1, 2'd0, 2'd3, 32'h0000_0077);
    dir_op("R11 pointer unchanged array", 0, 2'd0, 8'h43, 0);
    // arbitration
    @(negedge clk);
    dir_req = 1; dir_we = 0; dir_size = 2'd2; dir_addr = 8'hAC;
    ind_req = 1; ind_sel = 1; ind_we = 0; ind_size = 2'd2; ind_addr = 0;
    @(posedge clk); #1;
    check("R10 direct served first", {30'h0, dir_ack, ind_ack}, 32'h2);
    check("R10 direct data", dir_rdata, {m[8'hAC], m[8'hAD], m[8'hAE], m[8'hAF]});
    dir_req = 0;
    @(posedge clk); #1;
    check("R10 indirect follows", {30'h0, dir_ack, ind_ack}, 32'h1);
    check("R10 indirect data", ind_rdata, {sh[0], sh[1], sh[2], sh[3]});
    ind_req = 0;
    // second variant
    do_reset(1);
    all_words("R1 extended defaults");
    ind_op("R12 shadow cleared ext", 1, 0, 2'd2, 2'd0, 0);
    ind_op("R12 pointer cleared write", 1, 1, 2'd0, 2'd0, 32'h0000_005A);
    dir_op("R12 pointer cleared array", 0, 2'd0, 8'h00, 0);
    done = 1;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule